// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Channel Select

This block is the digital side of an 8-bit successive-approximation converter that has an eight-way input selector in front of it. A 3-bit channel number is captured when the address strobe rises. The capture drives a one-hot select word toward the analog selector. A start pulse clears the approximation register when it rises, and the bit trials begin after it falls. For each trial the block presents a code to an external DAC and comparator, then reads back one comparator bit. When the last bit is settled, the block loads the result register. One clock later it raises the end-of-conversion flag.

The result leaves the block through an output gate. When the enable is low the data bus reads zero and a valid flag reports that the bus is not being driven. This stands in for a three-state bus. The start and strobe inputs may be asynchronous to the conversion clock, so both pass through synchronizer chains before their edges are detected. A new start pulse aborts any conversion in progress. If the end-of-conversion flag is fed back into start, the block runs continuously once a single external start pulse has been applied.

Top module: `sar_adc_ctrl`

## Requirements
- R1: On a rising edge of `addr_strobe`, the value on `chan_addr` is captured. Code n (0 to 7) sets bit n of `chan_sel` and clears every other bit. After reset `chan_sel` is 8'b0000_0001.
- R2: A rising edge on `start` clears `trial_code` to zero and drives `eoc` low. When `eoc` was high, it goes low no more than 8 clocks after `start` is first sampled high.
- R3: While `start` stays high after its rising edge, no trials run and `trial_code` stays zero.
- R4: After `start` falls, 8 trials run from the MSB down to the LSB, each lasting 8 clocks. At the start of a trial its bit is set in `trial_code`. In the trial's last clock `cmp_below` is sampled, and if it is 1 (input below the trial level) the bit is cleared. The finished code equals the input level, with the code positive-true.
- R5: A rising edge on `start` during a conversion aborts that conversion and restarts the sequence. The aborted conversion never raises `eoc`.
- R6: The result register takes the new code exactly one clock before `eoc` rises. `eoc` stays high until the next start.
- R7: With `data_oe` high, `data_out` shows the result register and `data_valid` is 1. With `data_oe` low, `data_out` is zero and `data_valid` is 0.
- R8: If `eoc` is fed back into `start`, conversions repeat on their own after one external start pulse.
- R9: After reset `eoc` is 0, `trial_code` is 0 and the result register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_addr | input | 3 | Channel number to capture |
| addr_strobe | input | 1 | Channel capture strobe, acts on its rising edge |
| start | input | 1 | Start of conversion; rising edge clears, falling edge runs |
| cmp_below | input | 1 | Comparator: 1 when the input is below the trial level |
| trial_code | output | 8 | Code presented to the external DAC |
| chan_sel | output | 8 | One-hot channel select |
| eoc | output | 1 | End of conversion |
| data_oe | input | 1 | Output enable for the result bus |
| data_out | output | 8 | Result bus, zero while disabled |
| data_valid | output | 1 | High while the result bus is driven |

## Verification
The bench uses the default parameters: 8 data bits, a 3-bit channel number, 8 clocks per trial and 2 synchronizer stages. At these values a conversion takes about 70 clocks. That is short enough to convert every one of the eight channels with targets at both ends of the code range and at alternating bit patterns. It also leaves room for an abort partway through a conversion and for several free-running loops with the flag fed back into start. Because the synchronizer depth is 2, the clear on a start edge lands three clocks after the edge is sampled. This is well inside the 8-clock limit, so the bench can measure that latency directly.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_HOLD   = 2'd1,
        SEQ_TRIAL  = 2'd2,
        SEQ_FINISH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/sar_edge_sync.sv
// Level synchronizer with a payload carried alongside, plus edge pulses.
module sar_edge_sync #(
    parameter int STAGES = 2,
    parameter int PAY_W  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    input  logic [PAY_W-1:0] pay_i,
    output logic             rise_o,
    output logic             fall_o,
    output logic [PAY_W-1:0] pay_o
);

    typedef struct packed {
        logic [STAGES-1:0]            lvl;
        logic                         prev;
        logic [STAGES-1:0][PAY_W-1:0] pay;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.lvl[0] = lvl_i;
        s_d.pay[0] = pay_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.lvl[i] = s_q.lvl[i-1];
            s_d.pay[i] = s_q.pay[i-1];
        end
        s_d.prev = s_q.lvl[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = s_q.lvl[STAGES-1] & ~s_q.prev;
    assign fall_o = ~s_q.lvl[STAGES-1] & s_q.prev;
    assign pay_o  = s_q.pay[STAGES-1];

endmodule

// File: rtl/sar_chan_latch.sv
// Holds the selected channel and decodes it to a one-hot select.
module sar_chan_latch #(
    parameter int CHAN_W = 3,
    localparam int NCH   = 1 << CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [CHAN_W-1:0] addr_i,
    output logic [NCH-1:0]    sel_o
);

    logic [CHAN_W-1:0] chan_d, chan_q;

    always_comb begin
        chan_d = chan_q;
        if (cap_i) begin
            chan_d = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else begin
            chan_q <= chan_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign sel_o[g] = (chan_q == CHAN_W'(g));
    end

endmodule

// File: rtl/sar_seq.sv
// Bit-trial sequencer, approximation register and result register.
module sar_seq
    import sar_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int TRIAL_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rise,
    input  logic              start_fall,
    input  logic              cmp_below,
    output logic [DATA_W-1:0] trial_code,
    output logic [DATA_W-1:0] result,
    output logic              eoc,
    output logic              in_hold,
    output logic              in_trial
);

    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int CNT_W = (TRIAL_CLKS > 1) ? $clog2(TRIAL_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRIAL_CLKS - 1);
    localparam logic [BIT_W-1:0] BIT_TOP  = BIT_W'(DATA_W - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [BIT_W-1:0]  bit_idx;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] code;
        logic [DATA_W-1:0] result;
        logic              eoc;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_rise) begin
            // clear and wait for the falling edge; result is left alone
            r_d.state = SEQ_HOLD;
            r_d.code  = '0;
            r_d.cnt   = '0;
            r_d.eoc   = 1'b0;
        end else begin
            unique case (r_q.state)
                SEQ_IDLE: begin
                end
                SEQ_HOLD: begin
                    if (start_fall) begin
                        r_d.state           = SEQ_TRIAL;
                        r_d.bit_idx         = BIT_TOP;
                        r_d.cnt             = '0;
                        r_d.code            = '0;
                        r_d.code[DATA_W-1]  = 1'b1;
                    end
                end
                SEQ_TRIAL: begin
                    if (r_q.cnt == CNT_LAST) begin
                        r_d.cnt = '0;
                        if (cmp_below) begin
                            r_d.code[r_q.bit_idx] = 1'b0;
                        end
                        if (r_q.bit_idx == '0) begin
                            r_d.state  = SEQ_FINISH;
                            r_d.result = r_d.code;
                        end else begin
                            r_d.bit_idx             = r_q.bit_idx - 1'b1;
                            r_d.code[r_d.bit_idx]   = 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                SEQ_FINISH: begin
                    r_d.eoc   = 1'b1;
                    r_d.state = SEQ_IDLE;
                end
                default: r_d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign trial_code = r_q.code;
    assign result     = r_q.result;
    assign eoc        = r_q.eoc;
    assign in_hold    = (r_q.state == SEQ_HOLD);
    assign in_trial   = (r_q.state == SEQ_TRIAL);

endmodule

// File: rtl/sar_out_gate.sv
// Result bus gating in place of a three-state driver.
module sar_out_gate #(
    parameter int DATA_W = 8
) (
    input  logic              oe_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    for (genvar g = 0; g < DATA_W; g++) begin : g_gate
        assign data_o[g] = data_i[g] & oe_i;
    end
    assign valid_o = oe_i;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int DATA_W      = 8,
    parameter int CHAN_W      = 3,
    parameter int TRIAL_CLKS  = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NCH        = 1 << CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAN_W-1:0] chan_addr,
    input  logic              addr_strobe,
    input  logic              start,
    input  logic              cmp_below,
    output logic [DATA_W-1:0] trial_code,
    output logic [NCH-1:0]    chan_sel,
    output logic              eoc,
    input  logic              data_oe,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid
);

    logic              start_rise, start_fall;
    logic              strobe_rise, strobe_fall;
    logic [CHAN_W-1:0] addr_sync;
    logic [0:0]        start_pay;
    logic [DATA_W-1:0] result_q;
    logic              in_hold, in_trial;

    sar_edge_sync #(.STAGES(SYNC_STAGES), .PAY_W(1)) u_start_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (start),
        .pay_i  (1'b0),
        .rise_o (start_rise),
        .fall_o (start_fall),
        .pay_o  (start_pay)
    );

    sar_edge_sync #(.STAGES(SYNC_STAGES), .PAY_W(CHAN_W)) u_strobe_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (addr_strobe),
        .pay_i  (chan_addr),
        .rise_o (strobe_rise),
        .fall_o (strobe_fall),
        .pay_o  (addr_sync)
    );

    sar_chan_latch #(.CHAN_W(CHAN_W)) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (strobe_rise),
        .addr_i (addr_sync),
        .sel_o  (chan_sel)
    );

    sar_seq #(.DATA_W(DATA_W), .TRIAL_CLKS(TRIAL_CLKS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rise (start_rise),
        .start_fall (start_fall),
        .cmp_below  (cmp_below),
        .trial_code (trial_code),
        .result     (result_q),
        .eoc        (eoc),
        .in_hold    (in_hold),
        .in_trial   (in_trial)
    );

    sar_out_gate #(.DATA_W(DATA_W)) u_gate (
        .oe_i    (data_oe),
        .data_i  (result_q),
        .data_o  (data_out),
        .valid_o (data_valid)
    );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int NCH    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eoc,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out,
    input logic [DATA_W-1:0] trial_code,
    input logic [NCH-1:0]    chan_sel,
    input logic [DATA_W-1:0] result_q,
    input logic              start_rise,
    input logic              in_hold,
    input logic              in_trial
);

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_sel) == 1);

    assert_rise_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_rise |=> (!eoc && trial_code == '0));

    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold |-> trial_code == '0);

    assert_abort_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rise && in_trial) |=> in_hold);

    assert_load_before_eoc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_q) |=> $rose(eoc));

    assert_bus_shows_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> data_out == result_q);

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.DATA_W(DATA_W), .NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eoc        (eoc),
    .data_oe    (data_oe),
    .data_out   (data_out),
    .trial_code (trial_code),
    .chan_sel   (chan_sel),
    .result_q   (result_q),
    .start_rise (start_rise),
    .in_hold    (in_hold),
    .in_trial   (in_trial)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;

    localparam int TR = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] chan_addr = '0;
    logic       addr_strobe = 1'b0;
    logic       start_ext = 1'b0;
    logic       loop_en = 1'b0;
    logic       start_in;
    logic       cmp_below;
    logic [7:0] trial_code;
    logic [7:0] chan_sel;
    logic       eoc;
    logic       data_oe = 1'b0;
    logic [7:0] data_out;
    logic       data_valid;

    int tgt [8];
    int checks = 0;
    int errors = 0;
    int eoc_rises = 0;
    int eoc_prev = 0;

    always #2 clk = ~clk;

    assign start_in = start_ext | (loop_en & eoc);

    // behavioural selector plus comparator
    always_comb begin
        int idx;
        idx = 0;
        for (int i = 0; i < 8; i++) if (chan_sel[i]) idx = i;
        cmp_below = tgt[idx] < int'(trial_code);
    end

    sar_adc_ctrl i_sar_adc_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_addr   (chan_addr),
        .addr_strobe (addr_strobe),
        .start       (start_in),
        .cmp_below   (cmp_below),
        .trial_code  (trial_code),
        .chan_sel    (chan_sel),
        .eoc         (eoc),
        .data_oe     (data_oe),
        .data_out    (data_out),
        .data_valid  (data_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: start and strobe seen after two sampling delays
    int m_s1, m_s2, m_p, a_s1, a_s2, a_p, a_y1, a_y2;
    int m_chan, m_st, m_bit, m_cnt, m_code, m_res, m_eoc;
    int rise_m, fall_m, arise_m, below_m;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_p = 0; a_s1 = 0; a_s2 = 0; a_p = 0; a_y1 = 0; a_y2 = 0;
            m_chan = 0; m_st = 0; m_bit = 0; m_cnt = 0; m_code = 0; m_res = 0; m_eoc = 0;
        end else begin
            rise_m  = int'(m_s2 == 1 && m_p == 0);
            fall_m  = int'(m_s2 == 0 && m_p == 1);
            arise_m = int'(a_s2 == 1 && a_p == 0);
            below_m = int'(tgt[m_chan] < m_code);
            if (arise_m != 0) m_chan = a_y2;
            if (rise_m != 0) begin
                m_st = 1; m_code = 0; m_eoc = 0; m_cnt = 0;
            end else begin
                case (m_st)
                    1: if (fall_m != 0) begin
                        m_st = 2; m_bit = 7; m_cnt = 0; m_code = 128;
                    end
                    2: if (m_cnt == TR - 1) begin
                        if (below_m != 0) m_code = m_code - (1 << m_bit);
                        m_cnt = 0;
                        if (m_bit == 0) begin
                            m_res = m_code; m_st = 3;
                        end else begin
                            m_bit = m_bit - 1;
                            m_code = m_code + (1 << m_bit);
                        end
                    end else m_cnt++;
                    3: begin m_eoc = 1; m_st = 0; end
                    default: ;
                endcase
            end
            m_p = m_s2; m_s2 = m_s1; m_s1 = int'(start_in);
            a_p = a_s2; a_s2 = a_s1; a_s1 = int'(addr_strobe);
            a_y2 = a_y1; a_y1 = int'(chan_addr);
        end
        #1;
        if (rst_n) begin
            chk(int'(eoc) == m_eoc, "R2 R6 eoc", int'(eoc), m_eoc);
            chk(int'(trial_code) == m_code, "R4 trial_code", int'(trial_code), m_code);
            chk(int'(chan_sel) == (1 << m_chan), "R1 chan_sel", int'(chan_sel), 1 << m_chan);
            chk(int'(data_out) == (data_oe ? m_res : 0), "R6 R7 data_out",
                int'(data_out), data_oe ? m_res : 0);
            if (eoc && eoc_prev == 0) eoc_rises++;
            eoc_prev = int'(eoc);
        end
    end

    task automatic select_chan(input int ch);
        @(negedge clk);
        chan_addr = 3'(ch);
        addr_strobe = 1'b1;
        repeat (3) @(negedge clk);
        addr_strobe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_ext = 1'b1;
        repeat (4) @(negedge clk);
        start_ext = 1'b0;
    endtask

    task automatic wait_eoc();
        for (int i = 0; i < 200 && !eoc; i++) @(negedge clk);
    endtask

    task automatic convert(input int ch);
        int lat;
        bit was_high;
        select_chan(ch);
        @(negedge clk);
        was_high = eoc;
        start_ext = 1'b1;
        lat = 0;
        for (int i = 0; i < 12 && eoc; i++) begin
            @(negedge clk);
            lat++;
        end
        if (was_high) chk(lat <= 8 && !eoc, "R2 eoc low latency", lat, 8);
        repeat (4) @(negedge clk);
        start_ext = 1'b0;
        wait_eoc();
        @(negedge clk);
        chk(int'(data_out) == tgt[ch], "R4 converted value", int'(data_out), tgt[ch]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r0;
        tgt = '{8'h00, 8'hFF, 8'h5A, 8'h80, 8'h7F, 8'h01, 8'hA5, 8'h3C};
        repeat (5) @(negedge clk);
        // R9 reset state
        chk(eoc == 1'b0, "R9 eoc reset", int'(eoc), 0);
        chk(trial_code == 8'h00, "R9 trial_code reset", int'(trial_code), 0);
        chk(chan_sel == 8'h01, "R1 R9 chan_sel reset", int'(chan_sel), 1);
        data_oe = 1'b1;
        @(negedge clk);
        chk(data_out == 8'h00, "R9 result reset", int'(data_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R4 every channel
        for (int ch = 0; ch < 8; ch++) begin
            convert(ch);
            chk(chan_sel == 8'(1 << ch), "R1 select", int'(chan_sel), 1 << ch);
        end

        // R3 start held high: no trials
        @(negedge clk);
        start_ext = 1'b1;
        repeat (30) @(negedge clk);
        chk(trial_code == 8'h00 && !eoc, "R3 held start", int'(trial_code), 0);
        start_ext = 1'b0;
        wait_eoc();

        // R5 abort mid conversion, then restart on another channel
        select_chan(2);
        eoc_rises = 0;
        pulse_start();
        repeat (30) @(negedge clk);
        chk(eoc == 1'b0 && trial_code != 8'h00, "R5 mid conversion", int'(trial_code), 1);
        select_chan(6);
        pulse_start();
        wait_eoc();
        @(negedge clk);
        chk(eoc_rises == 1, "R5 single completion", eoc_rises, 1);
        chk(int'(data_out) == tgt[6], "R5 restarted result", int'(data_out), tgt[6]);

        // R7 output gate
        data_oe = 1'b0;
        @(negedge clk);
        chk(data_out == 8'h00 && !data_valid, "R7 disabled bus", int'(data_out), 0);
        data_oe = 1'b1;
        @(negedge clk);
        chk(int'(data_out) == tgt[6] && data_valid, "R7 enabled bus", int'(data_out), tgt[6]);

        // R8 free-running with eoc fed back
        select_chan(4);
        loop_en = 1'b1;
        r0 = eoc_rises;
        pulse_start();
        repeat (400) @(negedge clk);
        chk(eoc_rises - r0 >= 4, "R8 free-running loops", eoc_rises - r0, 4);
        loop_en = 1'b0;
        repeat (100) @(negedge clk);
        chk(int'(data_out) == tgt[4], "R8 free-running result", int'(data_out), tgt[4]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule